// File: doc/BRIEF.md
# Line Interface Reset and Calibration Sequencer

This block sequences the bring-up and the resets of a line-interface device. Once the supply-good indication rises, it waits a power-on settling interval of about 10 ms, measured in system-clock cycles. It then asks the transmit and receive sections to calibrate. Each section's calibration request stays pending until that section has a toggling reference clock. The transmit section takes its reference from the transmit clock. The receive section takes the master clock when that clock is active and falls back to the crystal oscillator otherwise.

A reset is requested by turning on both loopback controls at once. In host mode this is a register write that carries both loopback bits set. In hardware mode both loopback pins must stay high for at least 200 ns. An accepted reset does four things, each a single-cycle pulse: it clears the register file, clears the network loopback function, presets loss-of-signal when the short-haul configuration is selected, and starts a new calibration of both sections. The register file, the calibration engines and the analog detectors sit outside this block and consume these pulses.

Top module: `seq_reset_cal_sequencer`

## Requirements
- R1: Take the cycle in which supply-good is first sampled high as cycle 0. The power-on wait then lasts POR_CYC = ceil(CLK_HZ * POR_DELAY_US / 1e6) further clock edges. A section whose reference is active gets its calibration-start pulse on the edge that follows. No calibration-start comes earlier.
- R2: The sequencer accepts a host reset when host_mode=1 and reg_wr_en=1 in the same sampled cycle as reg_wr_remote_lb=1 and reg_wr_local_lb=1. The following cycle then carries one-cycle pulses on regs_clear, loopback_clear and the calibration starts.
- R3: A host write that sets only one of the two loopback bits causes no reset. So do loopback bits that arrive without reg_wr_en.
- R4: los_preset pulses together with regs_clear only when short_haul=1. When short_haul=0 it stays low.
- R5: In hardware mode (host_mode=0), a reset is produced when pin_remote_lb and pin_local_lb are both sampled high on HOLD_CYC = ceil(CLK_HZ * HW_HOLD_NS / 1e9) consecutive edges. The reset pulse follows the last of these edges. A shorter overlap produces no reset.
- R6: Pins held high past HOLD_CYC produce exactly one reset. A new reset needs the pins to drop first.
- R7: Host writes are ignored in hardware mode. The loopback pins are ignored in host mode.
- R8: A calibration request waits until its reference is active. The transmit reference is tx_ref_active. The receive reference is mclk_active OR xtal_active.
- R9: rx_ref_sel_mclk is 1 (master clock chosen) one cycle after mclk_active is sampled high, and 0 (crystal chosen) one cycle after it is sampled low.
- R10: While supply-good is low, and during rst, every output is 0 and any pending calibration is dropped.
- R11: Reset requests that arrive during the power-on wait are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply above operating threshold (synchronous) |
| host_mode | input | 1 | 1 = reset comes from register writes, 0 = from pins |
| short_haul | input | 1 | Short-haul configuration selected |
| reg_wr_en | input | 1 | Write strobe to the loopback control register |
| reg_wr_remote_lb | input | 1 | Remote loopback bit of the write data |
| reg_wr_local_lb | input | 1 | Local loopback bit of the write data |
| pin_remote_lb | input | 1 | Remote loopback pin (hardware mode) |
| pin_local_lb | input | 1 | Local loopback pin (hardware mode) |
| tx_ref_active | input | 1 | Transmit reference clock detected toggling |
| mclk_active | input | 1 | Master clock detected toggling |
| xtal_active | input | 1 | Crystal oscillator detected toggling |
| regs_clear | output | 1 | One-cycle pulse: clear all registers |
| loopback_clear | output | 1 | One-cycle pulse: cancel network loopback |
| los_preset | output | 1 | One-cycle pulse: force loss-of-signal high |
| tx_cal_start | output | 1 | One-cycle pulse: start transmit calibration |
| rx_cal_start | output | 1 | One-cycle pulse: start receive calibration |
| rx_ref_sel_mclk | output | 1 | 1 = receive reference is master clock, 0 = crystal |

## Verification
The host reset path is driven with a vector table that sweeps mode, short-haul, strobe and the two loopback bits. This separates a true two-bit reset from a one-bit write, from bits sent without a strobe, and from a write made in the wrong mode, and it shows whether los_preset follows the short-haul flag. The pin path is held for one cycle less than the hold time, then for exactly the hold time, then for well past it. This shows where the threshold lies and that a long hold gives only one reset. The power-on sequence runs with the receive references idle and a host reset issued during the wait. This tells apart the end of the timer, a request that stays pending, and an early reset that must be ignored. A final supply drop confirms that every output falls back to 0.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [1:0] {
        PWR_OFF   = 2'd0,
        PWR_WAIT  = 2'd1,
        PWR_READY = 2'd2
    } pwr_state_e;

    localparam int unsigned NUM_SECT = 2;
    localparam int unsigned SECT_TX  = 0;
    localparam int unsigned SECT_RX  = 1;

    typedef struct packed {
        logic regs_clear;
        logic lb_clear;
        logic los_preset;
    } rst_action_t;

    function automatic int unsigned cycles_for(longint hz, longint amount, longint per_sec);
        longint c;
        c = (hz * amount + per_sec - 1) / per_sec;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/seq_por_timer.sv
module seq_por_timer
    import seq_pkg::*;
#(
    parameter int unsigned DELAY_CYC = 500000
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    output logic ready_o,
    output logic start_o
);
    localparam int unsigned CW = $clog2(DELAY_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(DELAY_CYC - 1);

    pwr_state_e     state_q;
    logic [CW-1:0]  cnt_q;
    logic           start_q;

    always_ff @(posedge clk) begin
        if (rst || !supply_ok) begin
            state_q <= PWR_OFF;
            cnt_q   <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            case (state_q)
                PWR_OFF: begin
                    state_q <= PWR_WAIT;
                    cnt_q   <= '0;
                end
                PWR_WAIT: begin
                    if (cnt_q == LAST) begin
                        state_q <= PWR_READY;
                        start_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= PWR_READY;
            endcase
        end
    end

    assign ready_o = (state_q == PWR_READY);
    assign start_o = start_q;

    // R1: the start pulse only ever accompanies entry into the ready state
    assert_start_on_entry_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_o) |-> start_o);
    assert_start_once_R1: assert property (@(posedge clk) disable iff (rst)
        start_o |=> !start_o);

endmodule

// File: rtl/seq_pin_reset_filter.sv
module seq_pin_reset_filter #(
    parameter int unsigned HOLD_CYC = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic both_high,
    output logic fire_o
);
    localparam int unsigned CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic          armed_q;

    assign fire_o = enable && both_high && armed_q && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !enable || !both_high) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
        end else begin
            if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
            if (fire_o) armed_q <= 1'b0;
        end
    end

    // R6: a continuous hold yields a single event
    assert_single_fire_R6: assert property (@(posedge clk) disable iff (rst)
        fire_o |=> !fire_o);

endmodule

// File: rtl/seq_cal_launch.sv
module seq_cal_launch (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic request,
    input  logic ref_active,
    output logic start_o
);
    logic pending_q;
    logic start_q;

    always_ff @(posedge clk) begin
        if (rst || !supply_ok) begin
            pending_q <= 1'b0;
            start_q   <= 1'b0;
        end else if ((pending_q || request) && ref_active) begin
            pending_q <= 1'b0;
            start_q   <= 1'b1;
        end else begin
            pending_q <= pending_q || request;
            start_q   <= 1'b0;
        end
    end

    assign start_o = start_q;

    // R8: calibration is only launched on a toggling reference
    assert_start_has_ref_R8: assert property (@(posedge clk) disable iff (rst)
        start_o |-> $past(ref_active));

endmodule

// File: rtl/seq_reset_cal_sequencer.sv
module seq_reset_cal_sequencer
    import seq_pkg::*;
#(
    parameter longint CLK_HZ       = 50000000,
    parameter longint POR_DELAY_US = 10000,
    parameter longint HW_HOLD_NS   = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic host_mode,
    input  logic short_haul,
    input  logic reg_wr_en,
    input  logic reg_wr_remote_lb,
    input  logic reg_wr_local_lb,
    input  logic pin_remote_lb,
    input  logic pin_local_lb,
    input  logic tx_ref_active,
    input  logic mclk_active,
    input  logic xtal_active,
    output logic regs_clear,
    output logic loopback_clear,
    output logic los_preset,
    output logic tx_cal_start,
    output logic rx_cal_start,
    output logic rx_ref_sel_mclk
);
    localparam int unsigned POR_CYC  = cycles_for(CLK_HZ, POR_DELAY_US, 64'd1000000);
    localparam int unsigned HOLD_CYC = cycles_for(CLK_HZ, HW_HOLD_NS, 64'd1000000000);

    logic por_ready;
    logic por_start;
    logic pin_fire;
    logic host_req;
    logic reset_ev;
    logic [NUM_SECT-1:0] sect_ref;
    logic [NUM_SECT-1:0] sect_start;
    rst_action_t act_q;
    logic refsel_q;

    seq_por_timer #(.DELAY_CYC(POR_CYC)) u_por (
        .clk       (clk),
        .rst       (rst),
        .supply_ok (supply_ok),
        .ready_o   (por_ready),
        .start_o   (por_start)
    );

    seq_pin_reset_filter #(.HOLD_CYC(HOLD_CYC)) u_pin (
        .clk       (clk),
        .rst       (rst),
        .enable    (por_ready && !host_mode),
        .both_high (pin_remote_lb && pin_local_lb),
        .fire_o    (pin_fire)
    );

    assign host_req = host_mode && reg_wr_en && reg_wr_remote_lb && reg_wr_local_lb;
    assign reset_ev = por_ready && (host_req || pin_fire);

    assign sect_ref[SECT_TX] = tx_ref_active;
    assign sect_ref[SECT_RX] = mclk_active || xtal_active;

    for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
        seq_cal_launch u_cal (
            .clk        (clk),
            .rst        (rst),
            .supply_ok  (supply_ok),
            .request    (por_start || reset_ev),
            .ref_active (sect_ref[s]),
            .start_o    (sect_start[s])
        );
    end

    always_ff @(posedge clk) begin
        if (rst || !supply_ok) begin
            act_q    <= '0;
            refsel_q <= 1'b0;
        end else begin
            act_q.regs_clear <= reset_ev;
            act_q.lb_clear   <= reset_ev;
            act_q.los_preset <= reset_ev && short_haul;
            refsel_q         <= mclk_active;
        end
    end

    assign regs_clear      = act_q.regs_clear;
    assign loopback_clear  = act_q.lb_clear;
    assign los_preset      = act_q.los_preset;
    assign tx_cal_start    = sect_start[SECT_TX];
    assign rx_cal_start    = sect_start[SECT_RX];
    assign rx_ref_sel_mclk = refsel_q;

    // R10: nothing is driven while the supply is down
    assert_quiet_unpowered_R10: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> !(regs_clear || loopback_clear || los_preset ||
                         tx_cal_start || rx_cal_start || rx_ref_sel_mclk));
    // R11: resets are only honoured after the power-on wait
    assert_clear_after_wait_R11: assert property (@(posedge clk) disable iff (rst)
        regs_clear |-> $past(por_ready));
    // R4: loss-of-signal preset only rides on a reset
    assert_los_with_reset_R4: assert property (@(posedge clk) disable iff (rst)
        los_preset |-> (regs_clear && loopback_clear));
    // R9: master clock chosen only when it was seen active
    assert_refsel_mclk_R9: assert property (@(posedge clk) disable iff (rst)
        rx_ref_sel_mclk |-> $past(mclk_active));

endmodule

// File: tb/seq_reset_cal_sequencer_tb.sv
module seq_reset_cal_sequencer_tb;

    localparam int POR_CYC  = 1000;   // 20 us at 50 MHz
    localparam int HOLD_CYC = 10;     // 200 ns at 50 MHz

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply_ok = 1'b0, host_mode = 1'b1, short_haul = 1'b0;
    logic reg_wr_en = 1'b0, reg_wr_remote_lb = 1'b0, reg_wr_local_lb = 1'b0;
    logic pin_remote_lb = 1'b0, pin_local_lb = 1'b0;
    logic tx_ref_active = 1'b1, mclk_active = 1'b0, xtal_active = 1'b0;
    logic regs_clear, loopback_clear, los_preset, tx_cal_start, rx_cal_start, rx_ref_sel_mclk;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #10 clk = ~clk;

    seq_reset_cal_sequencer #(
        .CLK_HZ(50000000), .POR_DELAY_US(20), .HW_HOLD_NS(200)
    ) u_dut (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .host_mode(host_mode),
        .short_haul(short_haul), .reg_wr_en(reg_wr_en),
        .reg_wr_remote_lb(reg_wr_remote_lb), .reg_wr_local_lb(reg_wr_local_lb),
        .pin_remote_lb(pin_remote_lb), .pin_local_lb(pin_local_lb),
        .tx_ref_active(tx_ref_active), .mclk_active(mclk_active),
        .xtal_active(xtal_active), .regs_clear(regs_clear),
        .loopback_clear(loopback_clear), .los_preset(los_preset),
        .tx_cal_start(tx_cal_start), .rx_cal_start(rx_cal_start),
        .rx_ref_sel_mclk(rx_ref_sel_mclk)
    );

    // host_mode, short_haul, wr_en, remote, local, expected reset, expected los
    typedef struct packed {
        logic hm, sh, we, rl, ll, exp_rst, exp_los;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
        '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        int pulses;
        repeat (3) tick();
        // R10: reset state, all outputs low
        chk("R10 regs_clear in reset", regs_clear, 1'b0);
        chk("R10 tx_cal_start in reset", tx_cal_start, 1'b0);
        chk("R10 rx_ref_sel in reset", rx_ref_sel_mclk, 1'b0);
        rst = 1'b0;
        tick();
        chk("R10 idle without supply", regs_clear | tx_cal_start | rx_cal_start, 1'b0);

        // R1 / R11 / R8: power-on wait, early reset ignored, rx without reference
        supply_ok = 1'b1;
        for (int n = 1; n <= POR_CYC + 2; n++) begin
            reg_wr_en = (n == 5); reg_wr_remote_lb = (n == 5); reg_wr_local_lb = (n == 5);
            tick();
            if (n == 6 || n == POR_CYC + 2)
                chk("R11 reset ignored during wait", regs_clear, 1'b0);
            if (n == POR_CYC + 1) chk("R1 no cal before delay", tx_cal_start, 1'b0);
            if (n == POR_CYC + 2) chk("R1 tx cal at delay end", tx_cal_start, 1'b1);
            if (n == POR_CYC + 2) chk("R8 rx waits for reference", rx_cal_start, 1'b0);
        end
        reg_wr_en = 1'b0; reg_wr_remote_lb = 1'b0; reg_wr_local_lb = 1'b0;
        repeat (3) tick();
        chk("R8 rx still pending", rx_cal_start, 1'b0);
        xtal_active = 1'b1;
        tick();
        chk("R8 rx cal on crystal", rx_cal_start, 1'b1);
        chk("R9 crystal selected", rx_ref_sel_mclk, 1'b0);
        tick();
        chk("R8 rx cal single pulse", rx_cal_start, 1'b0);
        mclk_active = 1'b1;
        tick();
        chk("R9 master clock selected", rx_ref_sel_mclk, 1'b1);

        // R2 / R3 / R4 / R7: host write table
        foreach (VECS[i]) begin
            host_mode = VECS[i].hm; short_haul = VECS[i].sh;
            reg_wr_en = VECS[i].we; reg_wr_remote_lb = VECS[i].rl; reg_wr_local_lb = VECS[i].ll;
            tick();
            reg_wr_en = 1'b0;
            chk("R2 R3 R7 regs_clear", regs_clear, VECS[i].exp_rst);
            chk("R2 loopback_clear", loopback_clear, VECS[i].exp_rst);
            chk("R4 los_preset", los_preset, VECS[i].exp_los);
            chk("R2 tx_cal_start", tx_cal_start, VECS[i].exp_rst);
            chk("R2 rx_cal_start", rx_cal_start, VECS[i].exp_rst);
            tick();
            chk("R2 pulse one cycle", regs_clear, 1'b0);
        end
        reg_wr_remote_lb = 1'b0; reg_wr_local_lb = 1'b0;

        // R5: pins held one cycle short
        host_mode = 1'b0; short_haul = 1'b1;
        pulses = 0;
        pin_remote_lb = 1'b1; pin_local_lb = 1'b1;
        for (int k = 1; k < HOLD_CYC; k++) begin
            tick();
            pulses += int'(regs_clear);
        end
        pin_remote_lb = 1'b0; pin_local_lb = 1'b0;
        tick();
        pulses += int'(regs_clear);
        chk("R5 short hold ignored", pulses == 0, 1'b1);

        // R5 / R6: exact hold then long hold
        pulses = 0;
        pin_remote_lb = 1'b1; pin_local_lb = 1'b1;
        for (int k = 1; k <= HOLD_CYC + 20; k++) begin
            tick();
            if (k == HOLD_CYC - 1) chk("R5 no reset before hold", regs_clear, 1'b0);
            if (k == HOLD_CYC) begin
                chk("R5 reset at hold", regs_clear, 1'b1);
                chk("R5 los on pin reset", los_preset, 1'b1);
            end
            pulses += int'(regs_clear);
        end
        chk("R6 one reset per hold", pulses == 1, 1'b1);
        pin_remote_lb = 1'b0; pin_local_lb = 1'b0;
        tick();

        // R7: pins ignored in host mode
        host_mode = 1'b1;
        pulses = 0;
        pin_remote_lb = 1'b1; pin_local_lb = 1'b1;
        for (int k = 1; k <= HOLD_CYC + 5; k++) begin
            tick();
            pulses += int'(regs_clear);
        end
        chk("R7 pins ignored in host mode", pulses == 0, 1'b1);
        pin_remote_lb = 1'b0; pin_local_lb = 1'b0;

        // R10: supply drop
        supply_ok = 1'b0;
        reg_wr_en = 1'b1; reg_wr_remote_lb = 1'b1; reg_wr_local_lb = 1'b1;
        tick();
        reg_wr_en = 1'b0;
        chk("R10 ref sel cleared", rx_ref_sel_mclk, 1'b0);
        chk("R10 no reset unpowered", regs_clear | tx_cal_start, 1'b0);

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule